// File: doc/BRIEF.md
# Pipelined CORDIC Magnitude Unit

This block turns a stream of complex samples into their magnitudes, sqrt(re² + im²), using vectoring-mode CORDIC. It uses shift-and-add arithmetic only, plus one constant multiply at the end. A sample with its valid flag may arrive on every clock. Each accepted sample leaves as one unsigned magnitude, a fixed number of cycles later and in arrival order.

Before the first iteration, a fold stage replaces the real part with its absolute value, so the vector lies in the right half-plane. The `STAGES` identical registered iterations then steer the imaginary part toward zero, and the real part grows to the magnitude multiplied by the CORDIC gain. No angle is tracked. A last registered stage multiplies by the rounded reciprocal of the gain, then rounds (or truncates) and clamps to the output width. The internal datapath carries guard bits for growth and fraction bits for precision. A typical use is after a spectrum unit, to produce the amplitude of each frequency bin.

Top module: `cordic_magnitude`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly STAGES+2 clock cycles (18 by default). Each accepted sample yields exactly one result, in arrival order.
- R2: While `rst_n` is low, `out_valid` and `out_mag` are 0. Samples that were in flight when reset was asserted never produce a result.
- R3: For any two's-complement inputs in any quadrant, `out_mag` lies within 2 LSB of sqrt(re² + im²).
- R4: Full-scale inputs, including -2^(IN_W-1) on either or both components, do not wrap. They stay within the R3 tolerance, for example about 46341 for (-32768, -32768).
- R5: A valid `out_mag` never exceeds sqrt(2)·2^(IN_W-1) + 2.
- R6: The input (0, 0) gives exactly 0.
- R7: While `out_valid` is low, `out_mag` keeps its previous value. Cycles with `in_valid` low do not disturb the results of the samples around them.
- R8: Back-to-back samples, one on every clock, are all accepted and give results on consecutive cycles.
- R9: The sample (re, im) and the sample (-re, im) give identical results, because only |re| enters the iterations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The sample on `in_re`/`in_im` is valid this cycle |
| in_re | input | IN_W | Real part, two's complement |
| in_im | input | IN_W | Imaginary part, two's complement |
| out_valid | output | 1 | `out_mag` holds a new result |
| out_mag | output | IN_W | Gain-corrected magnitude, unsigned |

## Verification
The assertions check the following on every cycle:
- The number of samples in flight never exceeds the pipeline depth.
- No result appears without an earlier accepted sample.
- The output holds while it is not valid.
- A valid magnitude stays under the full-scale ceiling.

Some behaviours show only in the bench's scenarios, against a real-valued square root:
- numeric accuracy across quadrants, axes and full-scale corners;
- the exact 18-cycle alignment of valid flags;
- the exact zero result;
- mirror symmetry in the sign of the real part;
- the discarding of in-flight samples by a mid-stream reset.

// File: rtl/cmag_pkg.sv
package cmag_pkg;

   // Reciprocal of the CORDIC gain for a given number of iterations,
   // quantised to q fraction bits and rounded to nearest.
   function automatic longint inv_gain_q(input int iters, input int q);
      real g;
      real p;
      real scale;
      g     = 1.0;
      p     = 1.0;
      scale = 1.0;
      for (int i = 0; i < iters; i++) begin
         g = g * $sqrt(1.0 + p);
         p = p * 0.25;
      end
      for (int j = 0; j < q; j++) scale = scale * 2.0;
      return longint'(scale / g);
   endfunction

endpackage

// File: rtl/cmag_prefold.sv
module cmag_prefold #(
   parameter int IN_W = 16,
   parameter int W    = 22,
   parameter int FRAC = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 v_i,
   input  logic signed [IN_W-1:0] re_i,
   input  logic signed [IN_W-1:0] im_i,
   output logic                 v_o,
   output logic signed [W-1:0]  x_o,
   output logic signed [W-1:0]  y_o
);

   logic signed [W-1:0] re_ext;
   logic signed [W-1:0] im_ext;
   logic signed [W-1:0] re_abs;

   assign re_ext = W'(re_i);
   assign im_ext = W'(im_i);
   // fold into right half-plane; extra width makes -2^(IN_W-1) safe
   assign re_abs = re_ext[W-1] ? -re_ext : re_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o <= 1'b0;
         x_o <= '0;
         y_o <= '0;
      end else begin
         v_o <= v_i;
         if (v_i) begin
            x_o <= re_abs <<< FRAC;
            y_o <= im_ext <<< FRAC;
         end
      end
   end

endmodule

// File: rtl/cmag_stage.sv
module cmag_stage #(
   parameter int W     = 22,
   parameter int SHIFT = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                v_i,
   input  logic signed [W-1:0] x_i,
   input  logic signed [W-1:0] y_i,
   output logic                v_o,
   output logic signed [W-1:0] x_o,
   output logic signed [W-1:0] y_o
);

   logic signed [W-1:0] x_sh;
   logic signed [W-1:0] y_sh;
   logic                y_nonneg;
   logic signed [W-1:0] x_nx;
   logic signed [W-1:0] y_nx;

   assign x_sh     = x_i >>> SHIFT;
   assign y_sh     = y_i >>> SHIFT;
   assign y_nonneg = ~y_i[W-1];

   // rotate toward the x axis: direction picked from the sign of y
   always_comb begin
      if (y_nonneg) begin
         x_nx = x_i + y_sh;
         y_nx = y_i - x_sh;
      end else begin
         x_nx = x_i - y_sh;
         y_nx = y_i + x_sh;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o <= 1'b0;
         x_o <= '0;
         y_o <= '0;
      end else begin
         v_o <= v_i;
         if (v_i) begin
            x_o <= x_nx;
            y_o <= y_nx;
         end
      end
   end

endmodule

// File: rtl/cmag_gain_fix.sv
module cmag_gain_fix #(
   parameter int W      = 22,
   parameter int FRAC   = 4,
   parameter int KW     = 16,
   parameter int STAGES = 16,
   parameter int OUT_W  = 16,
   parameter bit ROUND  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                v_i,
   input  logic signed [W-1:0] x_i,
   output logic                v_o,
   output logic [OUT_W-1:0]    mag_o
);

   localparam int     PW = W + KW + 1;
   localparam int     SH = KW + FRAC;
   localparam longint KQ = cmag_pkg::inv_gain_q(STAGES, KW);
   localparam logic [PW-1:0] MAXO = PW'({OUT_W{1'b1}});

   logic [PW-1:0]    prod;
   logic [PW-1:0]    scaled;
   logic [OUT_W-1:0] mag_nx;

   // x is never negative after the fold, so treat it as unsigned
   assign prod = PW'($unsigned(x_i)) * PW'(KQ);

   generate
      if (ROUND) begin : g_round
         assign scaled = (prod + (PW'(1) << (SH - 1))) >> SH;
      end else begin : g_trunc
         assign scaled = prod >> SH;
      end
   endgenerate

   assign mag_nx = (scaled > MAXO) ? MAXO[OUT_W-1:0] : scaled[OUT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o   <= 1'b0;
         mag_o <= '0;
      end else begin
         v_o <= v_i;
         if (v_i) mag_o <= mag_nx;
      end
   end

endmodule

// File: rtl/cordic_magnitude.sv
module cordic_magnitude #(
   parameter int IN_W   = 16,
   parameter int STAGES = 16,
   parameter int GUARD  = 2,
   parameter int FRAC   = 4,
   parameter int KW     = 16,
   parameter bit ROUND  = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic signed [IN_W-1:0] in_re,
   input  logic signed [IN_W-1:0] in_im,
   output logic                   out_valid,
   output logic [IN_W-1:0]        out_mag
);

   localparam int W       = IN_W + GUARD + FRAC;
   localparam int OUT_W   = IN_W;
   localparam int LATENCY = STAGES + 2;

   generate
      if (IN_W < 4 || IN_W > 30) begin : g_bad_in_w
         $error("cordic_magnitude: IN_W out of range");
      end
      if (STAGES < 4 || STAGES > W - 1) begin : g_bad_stages
         $error("cordic_magnitude: STAGES out of range");
      end
      if (GUARD < 2) begin : g_bad_guard
         $error("cordic_magnitude: GUARD must be at least 2");
      end
      if (FRAC < 0 || KW < 8 || KW > 30) begin : g_bad_frac
         $error("cordic_magnitude: FRAC or KW out of range");
      end
   endgenerate

   logic                v_p [0:STAGES];
   logic signed [W-1:0] x_p [0:STAGES];
   logic signed [W-1:0] y_p [0:STAGES];

   cmag_prefold #(.IN_W(IN_W), .W(W), .FRAC(FRAC)) u_fold (
      .clk  (clk),
      .rst_n(rst_n),
      .v_i  (in_valid),
      .re_i (in_re),
      .im_i (in_im),
      .v_o  (v_p[0]),
      .x_o  (x_p[0]),
      .y_o  (y_p[0])
   );

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_iter
         cmag_stage #(.W(W), .SHIFT(g)) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .v_i  (v_p[g]),
            .x_i  (x_p[g]),
            .y_i  (y_p[g]),
            .v_o  (v_p[g+1]),
            .x_o  (x_p[g+1]),
            .y_o  (y_p[g+1])
         );
      end
   endgenerate

   cmag_gain_fix #(
      .W(W), .FRAC(FRAC), .KW(KW), .STAGES(STAGES), .OUT_W(OUT_W), .ROUND(ROUND)
   ) u_fix (
      .clk  (clk),
      .rst_n(rst_n),
      .v_i  (v_p[STAGES]),
      .x_i  (x_p[STAGES]),
      .v_o  (out_valid),
      .mag_o(out_mag)
   );

endmodule

// File: rtl/cordic_magnitude_chk.sv
module cordic_magnitude_chk #(
   parameter int IN_W    = 16,
   parameter int LATENCY = 18
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            out_valid,
   input logic [IN_W-1:0] out_mag
);

   localparam longint CAP = ((longint'(1) << (IN_W - 1)) * 1415) / 1000 + 2;

   int unsigned pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 0;
      else        pend <= pend + 32'(in_valid) - 32'(out_valid);
   end

   // R1: never more samples in flight than pipeline registers
   p_depth_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pend <= LATENCY);

   // R1: every result is backed by an earlier accepted sample
   p_no_orphan_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> pend > 0);

   // R7: output holds while not valid
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_mag));

   // R5: magnitude ceiling
   p_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> longint'(out_mag) <= CAP);

endmodule

bind cordic_magnitude cordic_magnitude_chk #(.IN_W(IN_W), .LATENCY(LATENCY)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .out_valid(out_valid),
   .out_mag  (out_mag)
);

// File: tb/test_cordic_magnitude.sv
`timescale 1ns/1ps
module test_cordic_magnitude;

   localparam int IN_W = 16;
   localparam int LAT  = 18;
   localparam int FS   = 1 << (IN_W - 1);

   typedef struct {
      bit    v;
      real   m;
      bit    mir;
      string tag;
   } exp_t;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b1;
   logic                   in_valid = 1'b0;
   logic signed [IN_W-1:0] in_re = '0;
   logic signed [IN_W-1:0] in_im = '0;
   logic                   out_valid;
   logic [IN_W-1:0]        out_mag;

   int          n_chk = 0;
   int          n_bad = 0;
   exp_t        q[$];
   logic [IN_W-1:0] prev_mag = '0;

   always #10 clk = ~clk;

   cordic_magnitude i_cordic_magnitude (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re),
      .in_im(in_im), .out_valid(out_valid), .out_mag(out_mag)
   );

   task automatic check_out(input exp_t e);
      real d;
      n_chk++;
      if (out_valid !== e.v) begin
         n_bad++;
         $display("FAIL R1: out_valid=%0b expected %0b", out_valid, e.v);
      end else if (e.v) begin
         d = real'(out_mag) - e.m;
         if (e.tag == "R6" && out_mag != 0) begin
            n_bad++;
            $display("FAIL R6: out_mag=%0d expected 0", out_mag);
         end else if (e.mir && out_mag != prev_mag) begin
            n_bad++;
            $display("FAIL R9: out_mag=%0d expected %0d", out_mag, prev_mag);
         end else if (d > 2.0 || d < -2.0) begin
            n_bad++;
            $display("FAIL %s: out_mag=%0d expected %f", e.tag, out_mag, e.m);
         end
      end else if (out_mag !== prev_mag) begin
         n_bad++;
         $display("FAIL R7: out_mag=%0d expected held %0d", out_mag, prev_mag);
      end
      prev_mag = out_mag;
   endtask

   task automatic step(input bit v, input int re, input int im,
                       input string tag, input bit mir = 1'b0);
      exp_t e;
      @(negedge clk);
      if (q.size() == LAT) check_out(q.pop_front());
      in_valid = v;
      in_re    = IN_W'(re);
      in_im    = IN_W'(im);
      e.v   = v;
      e.m   = $sqrt(real'(re) * real'(re) + real'(im) * real'(im));
      e.mir = mir;
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic do_reset();
      exp_t e;
      @(negedge clk);
      rst_n    = 1'b0;
      in_valid = 1'b0;
      q.delete();
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         n_chk++;
         if (out_valid !== 1'b0 || out_mag !== '0) begin
            n_bad++;
            $display("FAIL R2: valid=%0b mag=%0d expected 0/0", out_valid, out_mag);
         end
      end
      rst_n = 1'b1;
      prev_mag = '0;
      e.v = 1'b0; e.m = 0.0; e.mir = 1'b0; e.tag = "R2";
      for (int k = 0; k < LAT; k++) q.push_back(e);
   endtask

   task automatic drain();
      for (int k = 0; k < LAT + 2; k++) step(1'b0, 0, 0, "R7");
   endtask

   initial begin
      int re;
      int im;
      #1 rst_n = 1'b0;
      do_reset();

      // R6: zero, then axes and small values (R3)
      step(1'b1, 0, 0, "R6");
      step(1'b1, 1000, 0, "R3");
      step(1'b1, 0, -1000, "R3");
      step(1'b1, -1000, 0, "R3");
      step(1'b1, 0, 1000, "R3");
      step(1'b1, 3, -4, "R3");
      step(1'b1, -1, 1, "R3");
      step(1'b1, 0, 0, "R6");
      drain();

      // R4 / R5: full-scale corners
      step(1'b1, -FS, -FS, "R4");
      step(1'b1, FS - 1, -FS, "R4");
      step(1'b1, -FS, FS - 1, "R5");
      step(1'b1, FS - 1, FS - 1, "R5");
      step(1'b1, -FS, 0, "R4");
      step(1'b1, 0, -FS, "R4");
      drain();

      // R9: mirrored pairs back to back
      for (int k = 0; k < 40; k++) begin
         re = $signed(IN_W'($urandom));
         im = $signed(IN_W'($urandom));
         if (re == -FS) re = -FS + 1;
         step(1'b1, re, im, "R3");
         step(1'b1, -re, im, "R9", 1'b1);
      end
      drain();

      // R8: long back-to-back burst, all quadrants
      for (int k = 0; k < 2000; k++) begin
         re = $signed(IN_W'($urandom));
         im = $signed(IN_W'($urandom));
         step(1'b1, re, im, "R8");
      end
      drain();

      // R7: sparse valid with gaps
      for (int k = 0; k < 600; k++) begin
         re = $signed(IN_W'($urandom));
         im = $signed(IN_W'($urandom));
         step(($urandom % 3) == 0, re, im, "R7");
      end
      drain();

      // R2: reset with pipeline full; in-flight samples must vanish
      for (int k = 0; k < LAT; k++) step(1'b1, 12345, -2345, "R3");
      do_reset();
      for (int k = 0; k < 100; k++) begin
         re = $signed(IN_W'($urandom));
         im = $signed(IN_W'($urandom));
         step(1'b1, re, im, "R3");
      end
      drain();

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule